// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block turns an asynchronous serial line into characters of 8 or 9 data bits. An input bit selects the character length. Each character is written into a holding register. A status word reports six conditions: a character is waiting, a character was lost, the line went quiet, a sample disagreed, the stop bit was bad, and the parity was wrong. The bit timing comes from an external tick that pulses sixteen times per bit. The block does not generate that tick itself.

Software reads the block through a one-bit-address read port. Address 0 returns the status word and address 1 returns the low eight data bits. A flag is cleared only by a two-step sequence: a status read that sees the flag set, then a data-low read. A waiting character is never overwritten. When a second character arrives before the first is read, that second character is dropped and the loss is flagged. The quiet-line flag is re-armed only by a newly accepted character.

An interrupt output combines the waiting-character condition and the quiet-line condition, each through its own enable input.

Top module: `serial_rx_flags`

## Requirements
- R1: A frame is one start bit (0), then 8 data bits when `mode9`=0 or 9 data bits when `mode9`=1, sent least significant bit first, then one stop bit. The read at `rd_addr`=1 returns data bits 7..0. Status bit 7 shows data bit 8 of the held character, and that bit is 0 for 8-bit characters.
- R2: Each bit is sampled on ticks 7, 8 and 9 of its 16 ticks, and a majority vote decides its value. If those three samples disagree in any bit of an accepted frame, status bit 3 (noise) is set, and the voted data is stored unchanged.
- R3: A voted stop bit of 0 sets status bit 4 (framing). The character is still stored and still sets the data-ready flag.
- R4: With `par_en`=1, the last data bit of the frame is the parity bit. Status bit 5 (parity) is set when the XOR of all data bits differs from `par_odd`: even parity when `par_odd`=0, odd parity when `par_odd`=1.
- R5: A frame that completes while status bit 0 (data ready) is clear is stored in the holding register and sets status bit 0.
- R6: A frame that completes while status bit 0 is set is discarded. It sets status bit 1 (overrun) at the middle of its stop bit, and the held character and its bits stay unchanged.
- R7: Status bit 2 (idle) sets after the line has been high for 160 ticks with `mode9`=0, or 176 ticks with `mode9`=1. The count starts after a frame's stop bit is sampled, and the bit sets only if a character has been accepted since idle was last cleared.
- R8: Once idle has been cleared, a quiet line of any length does not set it again until a new character is accepted.
- R9: A data-low read clears exactly the flags that the most recent status read saw set. A flag that was set after that status read stays set.
- R10: A data-low read with no status read before it since the last data-low read leaves every flag unchanged.
- R11: `irq` is high one cycle after (data ready and `rie`) or (idle and `iie`) is true.
- R12: After reset all flags are 0, `irq` is 0, and the status read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse, 16 per bit time |
| rxd | input | 1 | Serial line, high when idle |
| mode9 | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Last data bit is checked as parity |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| rie | input | 1 | Interrupt enable for data ready |
| iie | input | 1 | Interrupt enable for idle |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 1 | 0: status word, 1: data bits 7..0 |
| rd_data | output | 8 | Registered read data, valid the cycle after the strobe |
| irq | output | 1 | Registered interrupt request |

## Verification
The in-line assertions check four things on every cycle. An overrun never changes the held character, and a data read with no status read before it never changes a flag. Idle rises only while it is armed. The interrupt follows its enabled sources. Only the bench scenarios can show the rest. This covers the stored values for whole sweeps of 8-bit and 9-bit characters, and noise injected inside one bit. It also covers the tick thresholds for idle in both modes, and the interleaved cases: a flag set between the two reads, and the re-arming of idle by a new character.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int DATA_W = 9;
  localparam int NFLAG  = 6;
  localparam int F_RDY  = 0;
  localparam int F_OVR  = 1;
  localparam int F_IDLE = 2;
  localparam int F_NSE  = 3;
  localparam int F_FRM  = 4;
  localparam int F_PAR  = 5;
  typedef enum logic [1:0] {S_WAIT, S_START, S_DATA, S_STOP} rx_state_t;
endpackage

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import rxs_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_raw,
  input  logic              mode9,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              line_s,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              nf,
  output logic              fe,
  output logic              pf
);
  localparam int PW = $clog2(OVS);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] P_A   = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] P_B   = PW'(OVS / 2);
  localparam logic [PW-1:0] P_C   = PW'(OVS / 2 + 1);
  localparam logic [PW-1:0] P_END = PW'(OVS - 1);

  logic [1:0]        sy;
  rx_state_t         state;
  logic [PW-1:0]     phase;
  logic [BW-1:0]     bitn;
  logic [BW-1:0]     nb;
  logic [1:0]        smp;
  logic              noise;
  logic              pen_q, podd_q;
  logic [DATA_W-1:0] shreg;
  logic              vote, dis;
  logic [DATA_W-1:0] wv;

  assign line_s = sy[1];
  assign busy   = (state != S_WAIT);
  assign vote   = (smp[1] & smp[0]) | (smp[1] & line_s) | (smp[0] & line_s);
  assign dis    = !((smp[1] == smp[0]) && (smp[0] == line_s));
  assign wv     = (nb == BW'(DATA_W)) ? shreg : (shreg >> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sy <= 2'b11;
    end else begin
      sy <= {sy[0], rx_raw};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_WAIT;
      phase  <= '0;
      bitn   <= '0;
      nb     <= BW'(DATA_W - 1);
      smp    <= 2'b11;
      noise  <= 1'b0;
      pen_q  <= 1'b0;
      podd_q <= 1'b0;
      shreg  <= '0;
      done   <= 1'b0;
      word   <= '0;
      nf     <= 1'b0;
      fe     <= 1'b0;
      pf     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        if (state == S_WAIT) begin
          if (!line_s) begin
            state  <= S_START;
            phase  <= PW'(1);
            noise  <= 1'b0;
            nb     <= mode9 ? BW'(DATA_W) : BW'(DATA_W - 1);
            pen_q  <= par_en;
            podd_q <= par_odd;
          end
        end else begin
          phase <= (phase == P_END) ? '0 : phase + PW'(1);
          if (phase == P_A || phase == P_B) begin
            smp <= {smp[0], line_s};
          end
          if (phase == P_C) begin
            noise <= noise | dis;
            case (state)
              S_START: if (vote) state <= S_WAIT;
              S_DATA:  shreg <= {vote, shreg[DATA_W-1:1]};
              S_STOP: begin
                done  <= 1'b1;
                word  <= wv;
                nf    <= noise | dis;
                fe    <= !vote;
                pf    <= pen_q && ((^wv) != podd_q);
                state <= S_WAIT;
              end
              default: ;
            endcase
          end
          if (phase == P_END) begin
            if (state == S_START) begin
              state <= S_DATA;
              bitn  <= '0;
            end else if (state == S_DATA) begin
              if (bitn == nb - BW'(1)) state <= S_STOP;
              else bitn <= bitn + BW'(1);
            end
          end
        end
      end
    end
  end

  // R1: a frame of at least ten bits cannot complete on two cycles in a row
  assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: completion is only ever reached from the stop-bit state
  assert_done_from_stop_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(state) == S_STOP));
endmodule

// File: rtl/rx_idle_watch.sv
module rx_idle_watch
  import rxs_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line_s,
  input  logic busy,
  input  logic mode9,
  output logic hit
);
  localparam int T8 = OVS * (DATA_W + 1);
  localparam int T9 = OVS * (DATA_W + 2);
  localparam int CW = $clog2(T9 + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] thr;

  assign thr = mode9 ? CW'(T9) : CW'(T8);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      hit <= tick && !busy && line_s && (cnt == thr - CW'(1));
      if (busy || !line_s) cnt <= '0;
      else if (tick && cnt < thr) cnt <= cnt + CW'(1);
    end
  end

  // R7: a quiet-line pulse only follows a high, non-receiving line
  assert_hit_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(line_s) && !$past(busy)));
endmodule

// File: rtl/rx_status_bank.sv
module rx_status_bank
  import rxs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] word,
  input  logic              nf,
  input  logic              fe,
  input  logic              pf,
  input  logic              hit,
  input  logic              rd_en,
  input  logic              rd_addr,
  input  logic              rie,
  input  logic              iie,
  output logic [7:0]        rd_data,
  output logic              irq
);
  logic [NFLAG-1:0]  flags, mask, clr, nxt;
  logic [DATA_W-1:0] data_q;
  logic              idle_arm;
  logic              st_rd, dl_rd, accept;

  assign st_rd  = rd_en && !rd_addr;
  assign dl_rd  = rd_en && rd_addr;
  assign clr    = dl_rd ? mask : '0;
  assign accept = done && (!flags[F_RDY] || clr[F_RDY]);

  always_comb begin
    nxt = flags & ~clr;
    if (accept) begin
      nxt[F_RDY] = 1'b1;
      nxt[F_NSE] = nxt[F_NSE] | nf;
      nxt[F_FRM] = nxt[F_FRM] | fe;
      nxt[F_PAR] = nxt[F_PAR] | pf;
    end
    if (done && !accept) nxt[F_OVR] = 1'b1;
    if (hit && idle_arm) nxt[F_IDLE] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags    <= '0;
      mask     <= '0;
      data_q   <= '0;
      idle_arm <= 1'b0;
      rd_data  <= '0;
      irq      <= 1'b0;
    end else begin
      flags <= nxt;
      if (st_rd) mask <= flags;
      else if (dl_rd) mask <= '0;
      if (accept) data_q <= word;
      if (accept) idle_arm <= 1'b1;
      else if (clr[F_IDLE]) idle_arm <= 1'b0;
      if (rd_en) begin
        rd_data <= rd_addr ? data_q[7:0]
                           : {data_q[DATA_W-1], {(7 - NFLAG){1'b0}}, flags};
      end
      irq <= (flags[F_RDY] && rie) || (flags[F_IDLE] && iie);
    end
  end

  // R6: the held character does not move in the cycle overrun rises
  assert_ovr_keeps_data_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_OVR]) |-> $stable(data_q));
  // R10: a lone data read changes no flag
  assert_lone_read_R10: assert property (@(posedge clk) disable iff (rst)
    (dl_rd && mask == '0 && !done && !hit) |=> (flags == $past(flags)));
  // R9: a seen data-ready flag is gone after the data read
  assert_seq_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (dl_rd && mask[F_RDY] && !done) |=> !flags[F_RDY]);
  // R8: idle rises only while armed by an accepted character
  assert_idle_armed_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[F_IDLE]) |-> $past(idle_arm));
  // R11: an enabled source raises the request on the next cycle
  assert_irq_follow_R11: assert property (@(posedge clk) disable iff (rst)
    ((flags[F_RDY] && rie) || (flags[F_IDLE] && iie)) |=> irq);
endmodule

// File: rtl/serial_rx_flags.sv
module serial_rx_flags
  import rxs_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       mode9,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rie,
  input  logic       iie,
  input  logic       rd_en,
  input  logic       rd_addr,
  output logic [7:0] rd_data,
  output logic       irq
);
  logic              line_s, busy, done, nf, fe, pf, hit;
  logic [DATA_W-1:0] word;

  rx_bit_engine #(.OVS(OVS)) u_eng (
    .clk(clk), .rst(rst), .tick(tick16), .rx_raw(rxd), .mode9(mode9),
    .par_en(par_en), .par_odd(par_odd), .line_s(line_s), .busy(busy),
    .done(done), .word(word), .nf(nf), .fe(fe), .pf(pf)
  );

  rx_idle_watch #(.OVS(OVS)) u_idle (
    .clk(clk), .rst(rst), .tick(tick16), .line_s(line_s), .busy(busy),
    .mode9(mode9), .hit(hit)
  );

  rx_status_bank u_stat (
    .clk(clk), .rst(rst), .done(done), .word(word), .nf(nf), .fe(fe),
    .pf(pf), .hit(hit), .rd_en(rd_en), .rd_addr(rd_addr), .rie(rie),
    .iie(iie), .rd_data(rd_data), .irq(irq)
  );

  // R12: nothing is flagged out of reset
  assert_reset_quiet_R12: assert property (@(posedge clk)
    $past(rst) |-> (!irq && rd_data == 8'h00));
endmodule

// File: tb/test_serial_rx_flags.sv
module test_serial_rx_flags;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic clk = 1'b0, rst = 1'b1, rxd = 1'b1, mode9 = 1'b0;
  logic par_en = 1'b0, par_odd = 1'b0, rie = 1'b0, iie = 1'b0;
  logic rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0] rd_data;
  logic irq;
  logic [1:0] div = '0;
  logic tick16;
  int total = 0, bad = 0;
  logic [8:0] last_w = '0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always_ff @(posedge clk) div <= div + 2'd1;
  assign tick16 = (div == 2'(TDIV - 1));

  serial_rx_flags i_serial_rx_flags (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .mode9(mode9),
    .par_en(par_en), .par_odd(par_odd), .rie(rie), .iie(iie),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic line(input logic v);
    @(posedge clk); #1 rxd = v;
    repeat (TDIV - 1) @(posedge clk);
  endtask

  task automatic send_bit(input logic v, input bit noisy);
    for (int j = 0; j < 16; j++) line((noisy && j == 8) ? ~v : v);
  endtask

  task automatic quiet(input int n);
    for (int k = 0; k < n; k++) line(1'b1);
  endtask

  task automatic send(input logic [8:0] w, input logic stopv, input int noise_at);
    int n;
    n = mode9 ? 9 : 8;
    send_bit(1'b0, noise_at == 0);
    for (int i = 0; i < n; i++) send_bit(w[i], noise_at == i + 1);
    send_bit(stopv, noise_at == n + 1);
    if (!stopv) quiet(16);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(posedge clk); #1 rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1 rd_en = 1'b0;
    v = rd_data;
  endtask

  function automatic int st(input int f);
    return {24'd0, last_w[8], 1'b0, 6'(f)};
  endfunction

  task automatic clear_all();
    logic [7:0] v;
    rd(1'b0, v); rd(1'b1, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [8:0] w;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1 chk("R12 irq after reset", irq, 0);
    rd(1'b0, v); chk("R12 status after reset", v, 0);

    // R1 R5 R9: 8-bit sweep
    for (int i = 0; i < 12; i++) begin
      w = 9'((i * 37 + 5) & 8'hFF);
      send(w, 1'b1, -1); last_w = w;
      rd(1'b0, v); chk("R5 ready flag 8-bit", v, st(1));
      rd(1'b1, v); chk("R1 data 8-bit", v, w[7:0]);
      rd(1'b0, v); chk("R9 cleared after sequence", v, st(0));
    end
    // R1: 9-bit sweep
    mode9 = 1'b1;
    for (int i = 0; i < 6; i++) begin
      w = 9'((i * 149 + 256) & 9'h1FF);
      send(w, 1'b1, -1); last_w = w;
      rd(1'b0, v); chk("R1 status bit7 9-bit", v, st(1));
      rd(1'b1, v); chk("R1 data 9-bit", v, w[7:0]);
    end
    mode9 = 1'b0;

    // R2 noise inside data bit 3
    send(9'h0B6, 1'b1, 4); last_w = 9'h0B6;
    rd(1'b0, v); chk("R2 noise flag", v, st(9));
    rd(1'b1, v); chk("R2 voted data", v, 8'hB6);

    // R3 framing
    send(9'h05A, 1'b0, -1); last_w = 9'h05A;
    rd(1'b0, v); chk("R3 framing flag", v, st(8'h11));
    rd(1'b1, v); chk("R3 data kept", v, 8'h5A);

    // R4 parity
    par_en = 1'b1;
    send(9'h003, 1'b1, -1); last_w = 9'h003;
    rd(1'b0, v); chk("R4 even ok", v, st(1)); rd(1'b1, v);
    send(9'h007, 1'b1, -1); last_w = 9'h007;
    rd(1'b0, v); chk("R4 even bad", v, st(8'h21)); rd(1'b1, v);
    par_odd = 1'b1;
    send(9'h007, 1'b1, -1);
    rd(1'b0, v); chk("R4 odd ok", v, st(1)); rd(1'b1, v);
    par_en = 1'b0; par_odd = 1'b0;

    // R6 overrun
    send(9'h03C, 1'b1, -1); last_w = 9'h03C;
    send(9'h0C3, 1'b1, -1);
    rd(1'b0, v); chk("R6 overrun flag", v, st(3));
    rd(1'b1, v); chk("R6 data held", v, 8'h3C);
    rd(1'b0, v); chk("R6 overrun cleared", v, st(0));

    // R10 lone data read
    send(9'h091, 1'b1, -1); last_w = 9'h091;
    rd(1'b1, v); chk("R10 data read", v, 8'h91);
    rd(1'b0, v); chk("R10 ready kept", v, st(1));
    rd(1'b1, v);

    // R7 idle thresholds, 8-bit
    send(9'h044, 1'b1, -1); last_w = 9'h044; clear_all();
    quiet(140); rd(1'b0, v); chk("R7 idle not yet m0", v, st(0));
    quiet(24);  rd(1'b0, v); chk("R7 idle set m0", v, st(4));
    rd(1'b1, v);
    // R7 idle thresholds, 9-bit
    mode9 = 1'b1;
    send(9'h022, 1'b1, -1); last_w = 9'h022; clear_all();
    quiet(156); rd(1'b0, v); chk("R7 idle not yet m1", v, st(0));
    quiet(24);  rd(1'b0, v); chk("R7 idle set m1", v, st(4));
    rd(1'b1, v);
    mode9 = 1'b0;

    // R9 flag set between the two reads survives
    send(9'h066, 1'b1, -1); last_w = 9'h066;
    rd(1'b0, v); chk("R9 seen ready", v, st(1));
    quiet(200); rd(1'b1, v);
    rd(1'b0, v); chk("R9 late idle kept", v, st(4));
    rd(1'b1, v);

    // R8 no re-arm without a character
    quiet(300); rd(1'b0, v); chk("R8 idle stays clear", v, st(0));
    send(9'h077, 1'b1, -1); last_w = 9'h077; clear_all();
    quiet(200); rd(1'b0, v); chk("R8 re-armed by frame", v, st(4));
    rd(1'b1, v);

    // R11 interrupt
    rie = 1'b1;
    send(9'h012, 1'b1, -1); last_w = 9'h012;
    repeat (2) @(posedge clk); #1 chk("R11 irq on ready", irq, 1);
    clear_all(); repeat (2) @(posedge clk); #1 chk("R11 irq drops", irq, 0);
    rie = 1'b0; iie = 1'b1;
    send(9'h034, 1'b1, -1); last_w = 9'h034;
    repeat (2) @(posedge clk); #1 chk("R11 ready masked", irq, 0);
    clear_all(); quiet(200); #1 chk("R11 irq on idle", irq, 1);
    clear_all(); repeat (2) @(posedge clk); #1 chk("R11 irq idle drops", irq, 0);
    iie = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule